// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block keeps bus time in one 32-bit word made of three counting fields of different radix. The lowest field counts timebase ticks inside one bus cycle. The middle field counts cycles inside one second. The top field counts seconds. Each pulse of a tick-enable strobe advances the word by one. The strobe is expected at 24.576 MHz, which gives 3072 ticks per 125 us cycle and 8000 cycles per second.

Every carry between fields settles within the clock edge that causes it. The packed word therefore never shows a field that has wrapped while its neighbour has not yet moved on. A host can overwrite the whole word through a load strobe. A read strobe copies the complete word into an output register in a single clock. The copy comes from one register, so it cannot mix bits from before and after an update.

Top module: `iso_cycle_timer`

## Requirements
- R1: After a synchronous reset, the live timer word and the read data are both all zeros.
- R2: A clock edge with tick_en high and load_en low adds one to the tick offset in bits 11:0. A clock edge with both strobes low leaves the whole word unchanged.
- R3: When the tick offset is 3071 and a tick arrives, the offset becomes 0 and the cycle count in bits 24:12 increases by one at that same edge.
- R4: When a tick wraps the offset while the cycle count is 7999, the cycle count becomes 0 and the seconds field in bits 31:25 increases by one at that same edge.
- R5: The seconds field wraps from 127 to 0 when it receives a carry.
- R6: A field that holds a value at or above its last count (3071 for the offset, 7999 for the cycle count) becomes 0 when it is advanced, and it passes a carry upward.
- R7: A clock edge with load_en high replaces the whole word with load_val. The load wins over a tick at the same edge.
- R8: A clock edge with rd_en high copies into rd_data the complete word that the timer held just before that edge. Between reads, rd_data keeps its value.
- R9: A read taken while the low six offset bits roll over from 63 to 64 returns correct low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle timebase tick strobe |
| load_en | input | 1 | Strobe that presets the timer word |
| load_val | input | 32 | Value to preset, packed as seconds:cycle:offset |
| rd_en | input | 1 | Strobe that captures a read snapshot |
| rd_data | output | 32 | Registered read snapshot |
| now_o | output | 32 | Live timer word |

## Verification
The checker tests on every cycle that each tick advances the offset by one. It also tests that the offset and cycle wraps carry into the next field at the same edge, that the seconds field wraps modulo 128, that idle cycles hold the word, that a load wins over a tick, and that each snapshot equals the word held before the edge. Some behaviours only the bench scenarios can show. These are the wrap of out-of-range loaded values, a read taken at the exact edge where a carry ripples through all three fields, the 63-to-64 rollover of the low offset bits, and multi-tick runs that start from chosen preset words.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int DEF_OFF_W   = 12;
  localparam int DEF_OFF_MOD = 3072;
  localparam int DEF_CYC_W   = 13;
  localparam int DEF_CYC_MOD = 8000;
  localparam int DEF_SEC_W   = 7;
  localparam int DEF_SEC_MOD = 128;
  localparam int NUM_FIELDS  = 3;

  typedef enum logic [1:0] {FLD_OFFSET = 2'd0, FLD_CYCLE = 2'd1, FLD_SECONDS = 2'd2} fld_e;
endpackage

// File: rtl/cyc_field_ctr.sv
module cyc_field_ctr #(
  parameter int W   = 12,
  parameter int MOD = 3072
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic at_end;
  assign at_end = (val >= LAST);
  // carry leaves this field in the same cycle as the wrap
  assign carry  = inc & at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
    end else if (ld) begin
      val <= ld_val;
    end else if (inc) begin
      val <= at_end ? '0 : val + W'(1);
    end
  end
endmodule

// File: rtl/cyc_read_snap.sv
module cyc_read_snap #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] src,
  output logic [W-1:0] dat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dat <= '0;
    end else if (cap) begin
      dat <= src;
    end
  end
endmodule

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer
  import cyc_timer_pkg::*;
#(
  parameter int OFF_W   = DEF_OFF_W,
  parameter int OFF_MOD = DEF_OFF_MOD,
  parameter int CYC_W   = DEF_CYC_W,
  parameter int CYC_MOD = DEF_CYC_MOD,
  parameter int SEC_W   = DEF_SEC_W,
  parameter int SEC_MOD = DEF_SEC_MOD,
  localparam int WORD_W = OFF_W + CYC_W + SEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_val,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] now_o
);
  logic [NUM_FIELDS:0] chain;
  logic [WORD_W-1:0]   word;

  // a load blocks the tick at the bottom of the carry chain
  assign chain[0] = tick_en & ~load_en;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int FW   = (i == 0) ? OFF_W   : (i == 1) ? CYC_W   : SEC_W;
    localparam int FMOD = (i == 0) ? OFF_MOD : (i == 1) ? CYC_MOD : SEC_MOD;
    localparam int LSB  = (i == 0) ? 0       : (i == 1) ? OFF_W   : OFF_W + CYC_W;
    logic [FW-1:0] fval;

    cyc_field_ctr #(.W(FW), .MOD(FMOD)) ctr_i (
      .clk    (clk),
      .rst    (rst),
      .inc    (chain[i]),
      .ld     (load_en),
      .ld_val (load_val[LSB +: FW]),
      .val    (fval),
      .carry  (chain[i+1])
    );
    assign word[LSB +: FW] = fval;
  end

  assign now_o = word;

  cyc_read_snap #(.W(WORD_W)) snap_i (
    .clk (clk),
    .rst (rst),
    .cap (rd_en),
    .src (word),
    .dat (rd_data)
  );
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
  parameter int OFF_W   = 12,
  parameter int OFF_MOD = 3072,
  parameter int CYC_W   = 13,
  parameter int CYC_MOD = 8000,
  parameter int SEC_W   = 7,
  localparam int WORD_W = OFF_W + CYC_W + SEC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              load_en,
  input logic [WORD_W-1:0] load_val,
  input logic              rd_en,
  input logic [WORD_W-1:0] rd_data,
  input logic [WORD_W-1:0] now_o
);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_MOD - 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_MOD - 1);

  logic [OFF_W-1:0] off;
  logic [CYC_W-1:0] cyc;
  logic [SEC_W-1:0] sec;
  logic             adv;
  assign off = now_o[OFF_W-1:0];
  assign cyc = now_o[OFF_W +: CYC_W];
  assign sec = now_o[WORD_W-1 -: SEC_W];
  assign adv = tick_en & ~load_en;

  // R2
  off_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv && off < OFF_LAST |=> off == $past(off) + OFF_W'(1) && cyc == $past(cyc));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en && !load_en |=> $stable(now_o));

  // R3
  off_carry_chk: assert property (@(posedge clk) disable iff (rst)
    adv && off == OFF_LAST && cyc < CYC_LAST |=> off == '0 && cyc == $past(cyc) + CYC_W'(1) && $stable(sec));

  // R4 R5
  sec_carry_chk: assert property (@(posedge clk) disable iff (rst)
    adv && off == OFF_LAST && cyc == CYC_LAST |=> off == '0 && cyc == '0 && sec == SEC_W'($past(sec) + SEC_W'(1)));

  // R7
  load_win_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> now_o == $past(load_val));

  // R8
  snap_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(now_o));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind iso_cycle_timer cyc_timer_chk #(
  .OFF_W(OFF_W), .OFF_MOD(OFF_MOD), .CYC_W(CYC_W), .CYC_MOD(CYC_MOD), .SEC_W(SEC_W)
) chk_i (
  .clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en), .load_val(load_val),
  .rd_en(rd_en), .rd_data(rd_data), .now_o(now_o)
);

// File: tb/iso_cycle_timer_tb_top.sv
module iso_cycle_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_val = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [31:0] now_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  iso_cycle_timer dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en),
    .load_val(load_val), .rd_en(rd_en), .rd_data(rd_data), .now_o(now_o)
  );

  localparam int NV = 10;
  localparam logic [31:0] V_START [NV] = '{
    {7'd0,   13'd0,    12'd0},
    {7'd0,   13'd0,    12'd3071},
    {7'd0,   13'd7999, 12'd3071},
    {7'd127, 13'd7999, 12'd3071},
    {7'd5,   13'd10,   12'd3070},
    {7'd0,   13'd7998, 12'd3071},
    {7'd3,   13'd0,    12'd100},
    {7'd0,   13'd0,    12'd4095},
    {7'd0,   13'd8191, 12'd3071},
    {7'd2,   13'd0,    12'd62}
  };
  localparam int V_TICKS [NV] = '{1, 1, 1, 1, 3, 1, 0, 1, 1, 3};
  localparam logic [31:0] V_EXP [NV] = '{
    {7'd0, 13'd0,    12'd1},
    {7'd0, 13'd1,    12'd0},
    {7'd1, 13'd0,    12'd0},
    {7'd0, 13'd0,    12'd0},
    {7'd5, 13'd11,   12'd1},
    {7'd0, 13'd7999, 12'd0},
    {7'd3, 13'd0,    12'd100},
    {7'd0, 13'd1,    12'd0},
    {7'd1, 13'd0,    12'd0},
    {7'd2, 13'd0,    12'd65}
  };
  localparam string V_REQ [NV] = '{"R2", "R3", "R4", "R5", "R3", "R3", "R2", "R6", "R6", "R9"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preset(input logic [31:0] v);
    load_en = 1'b1; load_val = v;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic read_now();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", now_o, 32'h0);
    check("R1", rd_data, 32'h0);

    // vector table: preset, tick, read back
    for (int i = 0; i < NV; i++) begin
      preset(V_START[i]);
      tick_en = 1'b1;
      for (int k = 0; k < V_TICKS[i]; k++) @(negedge clk);
      tick_en = 1'b0;
      check(V_REQ[i], now_o, V_EXP[i]);
      read_now();
      check({V_REQ[i], " R8"}, rd_data, V_EXP[i]);
    end

    // R2 idle cycles hold the word
    preset({7'd9, 13'd77, 12'd500});
    repeat (5) @(negedge clk);
    check("R2", now_o, {7'd9, 13'd77, 12'd500});

    // R7 load beats tick at the same edge
    tick_en = 1'b1;
    preset({7'd1, 13'd2, 12'd3});
    tick_en = 1'b0;
    check("R7", now_o, {7'd1, 13'd2, 12'd3});

    // R8 read at the edge of a full carry ripple returns the old word
    preset({7'd4, 13'd7999, 12'd3071});
    tick_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; rd_en = 1'b0;
    check("R8", rd_data, {7'd4, 13'd7999, 12'd3071});
    check("R4", now_o, {7'd5, 13'd0, 12'd0});
    // R8 snapshot holds while the timer moves on
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b0;
    check("R8", rd_data, {7'd4, 13'd7999, 12'd3071});
    read_now();
    check("R8", rd_data, {7'd5, 13'd0, 12'd4});

    // R9 reads on every tick across the 63 to 64 rollover
    preset({7'd0, 13'd0, 12'd62});
    tick_en = 1'b1; rd_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9", rd_data, {7'd0, 13'd0, 12'(62 + k)});
    end
    tick_en = 1'b0; rd_en = 1'b0;

    // R1 reset in mid-count clears both registers
    preset({7'd50, 13'd50, 12'd50});
    read_now();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", now_o, 32'h0);
    check("R1", rd_data, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule